// File: doc/BRIEF.md
# Peripheral Interrupt Aggregator with Edge Latching

This block collects a bank of peripheral interrupt request lines and folds them onto a few general-purpose event inputs. Each source has an enable bit. The enabled sources that belong to the same event are ORed together. A fixed parameter table decides which event each source belongs to. Software can always read the raw level of every source line, whatever the enable bits hold. From that read it can tell which of several sources sharing an event raised it.

Each event input feeds a two-stage rising-edge detector. A detected edge sets a latch bit. A latched event is offered as a request, but only while the global enable is on. When the consumer acknowledges the request, the event's pending bit sets and its latch clears in the same cycle. While the event stays pending, a later edge on its input is caught again in the latch. A return pulse clears the pending bit.

A separate per-source wake mask drives a wake output, and only while the core reports that it is idle.

Top module: `irq_aggregator`

## Requirements
- R1: The enable register sits at word offset 0 and resets to all zeros. A write there is read back unchanged. Offset 3 reads as zero.
- R2: Offset 1 returns the current level of every source line, bit n for source n, whatever the enable bits hold. A write to offset 1 changes neither the enable register nor the wake register.
- R3: The wake mask sits at word offset 2 and resets to zero. wake_o is high exactly when idle_i is high and at least one source is high with its wake bit set. The enable bits do not take part in wake_o.
- R4: A source whose enable bit is 0 never sets a latch bit.
- R5: An enabled source can raise its event input. The latch bit is observed set after the second clock edge following that rise, and is still clear after the first. An input held high does not retrigger the latch.
- R6: evt_req_o[e] is high when latch bit e is set and the global enable is on. The global enable resets to off. gie_set_i turns it on and gie_clr_i turns it off. When both arrive in the same cycle, the clear wins. Latch bits keep their value while requests are gated off.
- R7: An acknowledge on ack_i[e] takes effect only while evt_req_o[e] is high. It then sets pending bit e and clears latch bit e at the same edge. Otherwise it changes nothing.
- R8: A rising edge on event input e while pending bit e is set is queued: it sets latch bit e again.
- R9: A pulse on ret_i[e] clears pending bit e. If an accepted acknowledge for e arrives in the same cycle, the acknowledge wins and the bit stays set.
- R10: Sources that share an event merge into one input. A second source rising while another on the same event is already high produces no new edge. Sources rising together produce a single latch set.
- R11: An acknowledge can be given in the cycle the request is first seen. The pending bit then sets at the third clock edge after the source rises, and is still clear after the second.
- R12: With the default table, source s maps to event s / (NUM_SRC / NUM_EVT). With 32 sources and 4 events, sources 8 to 15 drive event 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_irq_i | input | NUM_SRC | Peripheral request lines, level |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word offset |
| reg_wdata_i | input | NUM_SRC | Register write data |
| reg_rdata_o | output | NUM_SRC | Register read data, combinational on reg_addr_i |
| gie_set_i | input | 1 | Global enable on command |
| gie_clr_i | input | 1 | Global enable off command |
| ack_i | input | NUM_EVT | Acknowledge pulse per event |
| ret_i | input | NUM_EVT | Return-from-event pulse per event |
| idle_i | input | 1 | Core idle indication |
| evt_req_o | output | NUM_EVT | Gated event requests |
| latch_o | output | NUM_EVT | Latched edge per event |
| pend_o | output | NUM_EVT | In-service flag per event |
| wake_o | output | 1 | Wake request while idle |

## Verification
The assertions check, on every cycle, several causal rules:
- a pending bit never rises without an acknowledge;
- a pending bit never rises without a request offered in the previous cycle;
- a pending bit never falls without a return pulse;
- a latch never rises unless an enabled source was high two edges earlier;
- requests are silent after a disable command;
- wake_o stays low while the core is busy.

The exact timing needs the bench scenarios. These cover the two-edge latch delay, the three-edge path to pending, and queueing of an edge while pending. They also cover merging of sources on a shared event, which event each source maps to, and the precedence when commands collide.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned MAP_FW  = 4;
  localparam int unsigned MAX_SRC = 64;
  localparam int unsigned MAP_W   = MAX_SRC * MAP_FW;

  typedef enum logic [1:0] {
    OFS_MASK = 2'd0,
    OFS_STAT = 2'd1,
    OFS_WAKE = 2'd2
  } reg_ofs_e;

  // Contiguous groups of nsrc/nevt sources per event
  function automatic logic [MAP_W-1:0] group_map(int unsigned nsrc, int unsigned nevt);
    logic [MAP_W-1:0] m;
    int unsigned grp;
    int unsigned ev;
    m   = '0;
    grp = (nsrc / nevt == 0) ? 1 : nsrc / nevt;
    for (int unsigned s = 0; s < MAX_SRC; s++) begin
      ev = s / grp;
      if (ev >= nevt) ev = nevt - 1;
      if (s < nsrc) m[s*MAP_FW +: MAP_FW] = MAP_FW'(ev);
    end
    return m;
  endfunction
endpackage

// File: rtl/irq_src_qualify.sv
module irq_src_qualify
  import irq_agg_pkg::*;
#(
  parameter int unsigned     NUM_SRC = 32,
  parameter int unsigned     NUM_EVT = 4,
  parameter logic [MAP_W-1:0] SRC_EVT_MAP = group_map(32, 4)
) (
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic [NUM_EVT-1:0] evt_o
);
  logic [NUM_SRC-1:0]              live;
  logic [NUM_EVT-1:0][NUM_SRC-1:0] sel;

  assign live = src_i & mask_i;

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      localparam logic HIT = (SRC_EVT_MAP[s*MAP_FW +: MAP_FW] == MAP_FW'(e));
      assign sel[e][s] = HIT & live[s];
    end
    assign evt_o[e] = |sel[e];
  end
endmodule

// File: rtl/irq_evt_channel.sv
module irq_evt_channel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic gie_i,
  input  logic ack_i,
  input  logic ret_i,
  output logic latch_o,
  output logic pend_o,
  output logic req_o
);
  logic sync_q, prev_q, latch_q, pend_q;
  logic edge_det, take;

  assign edge_det = sync_q & ~prev_q;
  assign req_o    = latch_q & gie_i;
  assign take     = ack_i & req_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 1'b0;
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      sync_q  <= evt_i;
      prev_q  <= sync_q;
      // a fresh edge in the accept cycle stays queued
      latch_q <= edge_det | (latch_q & ~take);
      if (take)       pend_q <= 1'b1;
      else if (ret_i) pend_q <= 1'b0;
    end
  end

  assign latch_o = latch_q;
  assign pend_o  = pend_q;
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               we_i,
  input  logic [1:0]         addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] rdata_o,
  input  logic               gie_set_i,
  input  logic               gie_clr_i,
  input  logic               idle_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic               gie_o,
  output logic               wake_o
);
  logic [NUM_SRC-1:0] mask_q, wake_q;
  logic               gie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      wake_q <= '0;
      gie_q  <= 1'b0;
    end else begin
      if (we_i && addr_i == OFS_MASK) mask_q <= wdata_i;
      if (we_i && addr_i == OFS_WAKE) wake_q <= wdata_i;
      if (gie_clr_i)      gie_q <= 1'b0;
      else if (gie_set_i) gie_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (addr_i)
      OFS_MASK: rdata_o = mask_q;
      OFS_STAT: rdata_o = src_i;
      OFS_WAKE: rdata_o = wake_q;
      default:  rdata_o = '0;
    endcase
  end

  assign wake_o = idle_i & (|(src_i & wake_q));
  assign mask_o = mask_q;
  assign gie_o  = gie_q;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned      NUM_SRC = 32,
  parameter int unsigned      NUM_EVT = 4,
  parameter logic [MAP_W-1:0] SRC_EVT_MAP = group_map(NUM_SRC, NUM_EVT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_irq_i,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [NUM_SRC-1:0] reg_wdata_i,
  output logic [NUM_SRC-1:0] reg_rdata_o,
  input  logic               gie_set_i,
  input  logic               gie_clr_i,
  input  logic [NUM_EVT-1:0] ack_i,
  input  logic [NUM_EVT-1:0] ret_i,
  input  logic               idle_i,
  output logic [NUM_EVT-1:0] evt_req_o,
  output logic [NUM_EVT-1:0] latch_o,
  output logic [NUM_EVT-1:0] pend_o,
  output logic               wake_o
);
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_EVT-1:0] evt_in;
  logic               gie_q;

  irq_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_i     (src_irq_i),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .gie_set_i (gie_set_i),
    .gie_clr_i (gie_clr_i),
    .idle_i    (idle_i),
    .mask_o    (mask_q),
    .gie_o     (gie_q),
    .wake_o    (wake_o)
  );

  irq_src_qualify #(
    .NUM_SRC     (NUM_SRC),
    .NUM_EVT     (NUM_EVT),
    .SRC_EVT_MAP (SRC_EVT_MAP)
  ) u_qual (
    .src_i  (src_irq_i),
    .mask_i (mask_q),
    .evt_o  (evt_in)
  );

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_chan
    irq_evt_channel u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .evt_i   (evt_in[e]),
      .gie_i   (gie_q),
      .ack_i   (ack_i[e]),
      .ret_i   (ret_i[e]),
      .latch_o (latch_o[e]),
      .pend_o  (pend_o[e]),
      .req_o   (evt_req_o[e])
    );
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned NUM_EVT = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_irq_i,
  input logic [NUM_SRC-1:0] mask_i,
  input logic               gie_clr_i,
  input logic [NUM_EVT-1:0] ack_i,
  input logic [NUM_EVT-1:0] ret_i,
  input logic               idle_i,
  input logic [NUM_EVT-1:0] evt_req_o,
  input logic [NUM_EVT-1:0] latch_o,
  input logic [NUM_EVT-1:0] pend_o,
  input logic               wake_o
);
  AST_PEND_SET_NEEDS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_o & ~$past(pend_o) & ~$past(ack_i)) == '0)); // R7
  AST_PEND_SET_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_o & ~$past(pend_o) & ~$past(evt_req_o)) == '0)); // R7
  AST_PEND_CLR_NEEDS_RET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~pend_o & $past(pend_o) & ~$past(ret_i)) == '0)); // R9
  AST_LATCH_NEEDS_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((latch_o & ~$past(latch_o)) != '0) |-> ($past(src_irq_i & mask_i, 2) != '0)); // R4
  AST_REQ_OFF_AFTER_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(gie_clr_i) |-> (evt_req_o == '0)); // R6
  AST_WAKE_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |-> !wake_o); // R3
endmodule

bind irq_aggregator irq_aggregator_chk #(.NUM_SRC(NUM_SRC), .NUM_EVT(NUM_EVT)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .src_irq_i (src_irq_i),
  .mask_i    (mask_q),
  .gie_clr_i (gie_clr_i),
  .ack_i     (ack_i),
  .ret_i     (ret_i),
  .idle_i    (idle_i),
  .evt_req_o (evt_req_o),
  .latch_o   (latch_o),
  .pend_o    (pend_o),
  .wake_o    (wake_o)
);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  localparam int unsigned NS = 32;
  localparam int unsigned NE = 4;

  typedef struct packed {
    logic [31:0] src;
    logic        idle;
    logic        wake;
  } vec_t;

  // wake mask = 0x0000_00F0 during the table walk
  localparam vec_t VECS [8] = '{
    '{32'h0000_0010, 1'b1, 1'b1},
    '{32'h0000_0010, 1'b0, 1'b0},
    '{32'h0000_0100, 1'b1, 1'b0},
    '{32'h0000_00F0, 1'b1, 1'b1},
    '{32'h0000_0000, 1'b1, 1'b0},
    '{32'h8000_0080, 1'b1, 1'b1},
    '{32'h8000_0000, 1'b1, 1'b0},
    '{32'h0000_0F0F, 1'b0, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic          we = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [NS-1:0] wdata = '0;
  logic [NS-1:0] rdata;
  logic          gset = 1'b0, gclr = 1'b0;
  logic [NE-1:0] ack = '0, ret = '0;
  logic          idle = 1'b0;
  logic [NE-1:0] req, latch, pend;
  logic          wake;
  int            n_vec = 0, n_err = 0;
  logic [31:0]   rv;

  always #2 clk = ~clk;

  irq_aggregator #(.NUM_SRC(NS), .NUM_EVT(NE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_irq_i(src), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .gie_set_i(gset), .gie_clr_i(gclr),
    .ack_i(ack), .ret_i(ret), .idle_i(idle), .evt_req_o(req), .latch_o(latch),
    .pend_o(pend), .wake_o(wake)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // R1 reset state
    rd(2'd0, rv); chk("R1 mask reset", rv, 32'h0);
    rd(2'd2, rv); chk("R3 wake mask reset", rv, 32'h0);
    chk("R6 req reset", 32'(req), 32'h0);
    chk("R5 latch reset", 32'(latch), 32'h0);
    chk("R7 pend reset", 32'(pend), 32'h0);
    // R1 write/read, unmapped offset
    wr(2'd0, 32'h0000_0F03);
    rd(2'd0, rv); chk("R1 mask readback", rv, 32'h0000_0F03);
    rd(2'd3, rv); chk("R1 offset3 zero", rv, 32'h0);
    // R2 write to status ignored
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd0, rv); chk("R2 mask untouched", rv, 32'h0000_0F03);
    rd(2'd2, rv); chk("R2 wake untouched", rv, 32'h0);
    // R4 masked source
    src[4] = 1'b1;
    rd(2'd1, rv); chk("R2 status shows masked src", rv, 32'h0000_0010);
    tick(); tick(); tick();
    chk("R4 masked no latch", 32'(latch), 32'h0);
    // R5 two-edge detection
    src[0] = 1'b1;
    tick(); chk("R5 latch clear after 1 edge", 32'(latch), 32'h0);
    tick(); chk("R5 latch set after 2 edges", 32'(latch), 32'h1);
    chk("R6 req gated off", 32'(req), 32'h0);
    tick(); tick(); chk("R5 held level no retrigger", 32'(latch), 32'h1);
    gset = 1'b1; tick(); gset = 1'b0;
    chk("R6 req on", 32'(req), 32'h1);
    // R7 ack on idle event ignored
    ack = 4'b0010; tick(); ack = '0;
    chk("R7 ack without req ignored", 32'(pend), 32'h0);
    ack = 4'b0001; tick(); ack = '0;
    chk("R7 pend set", 32'(pend), 32'h1);
    chk("R7 latch cleared", 32'(latch), 32'h0);
    // R10 second source on same event merges
    src[1] = 1'b1;
    tick(); tick(); tick();
    chk("R10 no edge on merge", 32'(latch), 32'h0);
    // R8 queue while pending
    src[1:0] = 2'b00; tick(); tick();
    src[0] = 1'b1; tick(); tick();
    chk("R8 queued latch", 32'(latch), 32'h1);
    chk("R8 still pending", 32'(pend), 32'h1);
    // R9 ack beats ret
    ack = 4'b0001; ret = 4'b0001; tick(); ack = '0; ret = '0;
    chk("R9 ack wins pend", 32'(pend), 32'h1);
    chk("R9 latch cleared", 32'(latch), 32'h0);
    ret = 4'b0001; tick(); ret = '0;
    chk("R9 ret clears", 32'(pend), 32'h0);
    // R12 mapping, R10 simultaneous
    src[10] = 1'b1; src[11] = 1'b1; src[9] = 1'b1;
    tick(); tick();
    chk("R12 src9-11 to event1", 32'(latch), 32'h2);
    chk("R6 req event1", 32'(req), 32'h2);
    gset = 1'b1; gclr = 1'b1; tick(); gset = 1'b0; gclr = 1'b0;
    chk("R6 clear wins", 32'(req), 32'h0);
    chk("R6 latch kept", 32'(latch), 32'h2);
    ack = 4'b0010; tick(); ack = '0;
    chk("R7 ack gated off ignored", 32'(pend), 32'h0);
    gset = 1'b1; tick(); gset = 1'b0;
    ack = 4'b0010; tick(); ack = '0;
    chk("R7 pend event1", 32'(pend), 32'h2);
    ret = 4'b0010; tick(); ret = '0;
    // R11 three-edge latency
    src = '0; tick(); tick();
    src[8] = 1'b1;
    tick(); chk("R11 pend clear at edge1", 32'(pend), 32'h0);
    tick(); chk("R11 pend clear at edge2", 32'(pend), 32'h0);
    chk("R12 src8 to event1", 32'(latch), 32'h2);
    ack = 4'b0010;
    tick(); ack = '0;
    chk("R11 pend set at edge3", 32'(pend), 32'h2);
    // R3/R2 vector table
    wr(2'd2, 32'h0000_00F0);
    foreach (VECS[i]) begin
      src = VECS[i].src; idle = VECS[i].idle;
      rd(2'd1, rv);
      chk($sformatf("R2 vec%0d status", i), rv, VECS[i].src);
      chk($sformatf("R3 vec%0d wake", i), 32'(wake), 32'(VECS[i].wake));
      tick();
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule